// File: doc/BRIEF.md
# Gated-Clock Parallel-Load Serializer

This block is an eight-stage register that takes a byte in parallel and shifts it out one bit at a time. It runs on a fast system clock. It treats the external shift clock and the clock-inhibit line as ordinary data signals. The logical OR of those two lines forms the effective shift clock. That OR passes through a small synchronizer, and each rising edge of it moves the register one place toward the output.

An active-low shift/load control works as a level-sensitive override. While it is low, every stage follows its parallel input, and the clock, inhibit and serial lines have no effect. While it is high, the parallel inputs are ignored and the register shifts: the first stage takes the serial input, and each later stage takes the value of the stage before it. The last stage drives a true serial output and a complemented serial output.

Because the clock and inhibit lines are symmetric, a rise of either one while the other is low causes a shift. Holding either one high blocks shifting by the other.

Top module: `gated_serializer`

## Requirements
- R1: After the active-low synchronous reset, all stages are 0, so `qOut` is 0 and `qOutN` is 1.
- R2: While `shLdN` is low, stage i holds `parIn[i]`. Bit 0 is the first stage and bit WIDTH-1 is the last stage. This holds whatever `extClk`, `extInh` and `serIn` do.
- R3: While `shLdN` is high, changes on `parIn` leave the register contents unchanged.
- R4: With `shLdN` high, each rising edge of (`extClk` OR `extInh`) causes exactly one shift. Stage 0 takes `serIn` and stage i takes the old value of stage i-1. The shift appears on `qOut` no more than SYNC_STAGES+2 system clocks after the edge.
- R5: With `extClk` low, a rise of `extInh` causes exactly one shift, and its later fall causes none.
- R6: With `shLdN` high and either `extClk` or `extInh` held high, toggling the other line does not change the contents.
- R7: `qOutN` is always the inverse of `qOut`.
- R8: If the effective clock rises while `shLdN` is low, releasing `shLdN` causes no shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| shLdN | input | 1 | Low: load from parIn; high: shift mode |
| extClk | input | 1 | External shift clock, sampled |
| extInh | input | 1 | Clock inhibit, interchangeable with extClk |
| serIn | input | 1 | Serial data into stage 0 |
| parIn | input | WIDTH | Parallel data; bit 0 loads stage 0 |
| qOut | output | 1 | Last stage |
| qOutN | output | 1 | Complement of last stage |

## Verification
The bench uses the default parameters, WIDTH=8 and SYNC_STAGES=2. With these values a whole byte can be shifted out, followed by eight serial-input bits, so every stage position and the full hand-off from parallel to serial data are observed. The short synchronizer keeps the edge-to-output latency at a few cycles. This lets the bench wait a fixed settle time after each edge on extClk or extInh, and then read the whole register back through qOut to confirm exactly one shift or none.

// File: rtl/gcs_pkg.sv
package gcs_pkg;
  typedef struct packed {
    logic load;
    logic shift;
  } gcsStrobes_t;
endpackage

// File: rtl/gcs_ctrl.sv
module gcs_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic                sysClk,
  input  logic                rstN,
  input  logic                shLdN,
  input  logic                extClk,
  input  logic                extInh,
  output gcs_pkg::gcsStrobes_t strb
);
  localparam int LastSync = SYNC_STAGES - 1;

  logic                   effClk;
  logic [SYNC_STAGES-1:0] syncChain;
  logic                   edgeHist;
  logic                   effSynced;

  assign effClk    = extClk | extInh;
  assign effSynced = syncChain[LastSync];

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge sysClk) begin
          if (!rstN) syncChain[g] <= 1'b0;
          else       syncChain[g] <= effClk;
        end
      end else begin : gRest
        always_ff @(posedge sysClk) begin
          if (!rstN) syncChain[g] <= 1'b0;
          else       syncChain[g] <= syncChain[g-1];
        end
      end
    end
  endgenerate

  // history keeps tracking during load so release never sees a stale low
  always_ff @(posedge sysClk) begin
    if (!rstN) edgeHist <= 1'b0;
    else       edgeHist <= effSynced;
  end

  always_comb begin
    strb.load  = ~shLdN;
    strb.shift = shLdN & effSynced & ~edgeHist;
  end
endmodule

// File: rtl/gcs_datapath.sv
module gcs_datapath #(
  parameter int WIDTH = 8
) (
  input  logic                 sysClk,
  input  logic                 rstN,
  input  gcs_pkg::gcsStrobes_t strb,
  input  logic                 serIn,
  input  logic [WIDTH-1:0]     parIn,
  output logic                 qOut,
  output logic                 qOutN
);
  localparam int LastStage = WIDTH - 1;

  logic [WIDTH-1:0] stageQ;

  genvar s;
  generate
    for (s = 0; s < WIDTH; s++) begin : gStage
      logic shiftSrc;
      if (s == 0) begin : gHead
        assign shiftSrc = serIn;
      end else begin : gBody
        assign shiftSrc = stageQ[s-1];
      end
      always_ff @(posedge sysClk) begin
        if (!rstN)          stageQ[s] <= 1'b0;
        else if (strb.load) stageQ[s] <= parIn[s];
        else if (strb.shift) stageQ[s] <= shiftSrc;
      end
    end
  endgenerate

  assign qOut  = stageQ[LastStage];
  assign qOutN = ~stageQ[LastStage];
endmodule

// File: rtl/gated_serializer.sv
module gated_serializer #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             sysClk,
  input  logic             rstN,
  input  logic             shLdN,
  input  logic             extClk,
  input  logic             extInh,
  input  logic             serIn,
  input  logic [WIDTH-1:0] parIn,
  output logic             qOut,
  output logic             qOutN
);
  gcs_pkg::gcsStrobes_t strb;

  gcs_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .sysClk(sysClk), .rstN(rstN), .shLdN(shLdN),
    .extClk(extClk), .extInh(extInh), .strb(strb)
  );

  gcs_datapath #(.WIDTH(WIDTH)) u_dp (
    .sysClk(sysClk), .rstN(rstN), .strb(strb), .serIn(serIn),
    .parIn(parIn), .qOut(qOut), .qOutN(qOutN)
  );
endmodule

// File: rtl/gated_serializer_chk.sv
module gated_serializer_chk (
  input logic                 sysClk,
  input logic                 rstN,
  input logic                 shLdN,
  input logic                 parMsb,
  input logic                 qOut,
  input logic                 qOutN,
  input gcs_pkg::gcsStrobes_t strb
);
  AST_OUT_COMPLEMENT: assert property (@(posedge sysClk) disable iff (!rstN)
    qOutN == ~qOut); // R7

  AST_RESET_CLEARS: assert property (@(posedge sysClk) disable iff (!rstN)
    $rose(rstN) |-> (qOut == 1'b0 && qOutN == 1'b1)); // R1

  AST_LOAD_FOLLOWS: assert property (@(posedge sysClk) disable iff (!rstN)
    !shLdN |=> qOut == $past(parMsb)); // R2

  AST_HOLD_NO_EDGE: assert property (@(posedge sysClk) disable iff (!rstN)
    (shLdN && !strb.shift) |=> $stable(qOut)); // R3

  AST_RELEASE_NO_SHIFT: assert property (@(posedge sysClk) disable iff (!rstN)
    $rose(shLdN) |-> !strb.shift); // R8
endmodule

bind gated_serializer gated_serializer_chk u_chk (
  .sysClk(sysClk), .rstN(rstN), .shLdN(shLdN), .parMsb(parIn[WIDTH-1]),
  .qOut(qOut), .qOutN(qOutN), .strb(strb)
);

// File: tb/tb_gated_serializer.sv
`timescale 1ns/1ps
module tb_gated_serializer;
  logic       sysClk = 1'b0;
  logic       rstN = 1'b0;
  logic       shLdN = 1'b1;
  logic       extClk = 1'b0;
  logic       extInh = 1'b0;
  logic       serIn = 1'b0;
  logic [7:0] parIn = 8'h00;
  logic       qOut, qOutN;

  int vectors = 0;
  int miscompares = 0;

  always #2 sysClk = ~sysClk;

  gated_serializer dut (
    .sysClk(sysClk), .rstN(rstN), .shLdN(shLdN), .extClk(extClk),
    .extInh(extInh), .serIn(serIn), .parIn(parIn), .qOut(qOut), .qOutN(qOutN)
  );

  task automatic waitCyc(input int n);
    repeat (n) @(negedge sysClk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
    // R7: every observation also checks the complement pair
    vectors++;
    if (qOutN !== ~qOut) begin
      miscompares++;
      $display("FAIL R7 actual qOutN=%b expected=%b", qOutN, ~qOut);
    end
  endtask

  task automatic pulseClk();
    extClk = 1'b1; waitCyc(6);
    extClk = 1'b0; waitCyc(6);
  endtask

  // Reads the register back, last stage first, bit7 = stage 7.
  task automatic readOut(output logic [7:0] v);
    serIn = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      v[i] = qOut;
      pulseClk();
    end
  endtask

  task automatic loadByte(input logic [7:0] b);
    parIn = b; shLdN = 1'b0; waitCyc(3);
    shLdN = 1'b1; waitCyc(3);
  endtask

  task automatic testReset();
    logic [7:0] v;
    rstN = 1'b0; waitCyc(4); rstN = 1'b1; waitCyc(1);
    chk("R1 qOut", {7'd0, qOut}, 8'h00);
    chk("R1 qOutN", {7'd0, qOutN}, 8'h01);
    readOut(v);
    chk("R1 contents", v, 8'h00);
  endtask

  task automatic testLoadShift();
    logic [7:0] pat = 8'hA5;
    logic [7:0] sIn = 8'h3C;
    parIn = pat; shLdN = 1'b0; serIn = 1'b1;
    extClk = 1'b1; waitCyc(4); extClk = 1'b0; extInh = 1'b1; waitCyc(4);
    extInh = 1'b0; waitCyc(4);
    chk("R2 load msb", {7'd0, qOut}, {7'd0, pat[7]});
    shLdN = 1'b1; waitCyc(4);
    for (int i = 7; i >= 0; i--) begin
      chk("R4 shift-out", {7'd0, qOut}, {7'd0, pat[i]});
      serIn = sIn[i];
      pulseClk();
    end
    for (int i = 7; i >= 0; i--) begin
      chk("R4 serial-in", {7'd0, qOut}, {7'd0, sIn[i]});
      serIn = 1'b0;
      pulseClk();
    end
  endtask

  task automatic testParIgnored();
    logic [7:0] v;
    loadByte(8'h0F);
    parIn = 8'hF0; waitCyc(8);
    chk("R3 qOut held", {7'd0, qOut}, 8'h00);
    readOut(v);
    chk("R3 contents", v, 8'h0F);
  endtask

  task automatic testInhShift();
    logic [7:0] v;
    serIn = 1'b0;
    loadByte(8'h81);
    chk("R5 before", {7'd0, qOut}, 8'h01);
    extInh = 1'b1; waitCyc(6);
    chk("R5 after rise", {7'd0, qOut}, 8'h00);
    extInh = 1'b0; waitCyc(6);
    readOut(v);
    chk("R5 one shift", v, 8'h02);
  endtask

  task automatic testHold();
    logic [7:0] v;
    parIn = 8'h5A; extClk = 1'b1; shLdN = 1'b0; waitCyc(4);
    shLdN = 1'b1; waitCyc(6);
    for (int k = 0; k < 3; k++) begin
      extInh = 1'b1; waitCyc(6); extInh = 1'b0; waitCyc(6);
    end
    extInh = 1'b1; waitCyc(6);
    for (int k = 0; k < 3; k++) begin
      extClk = 1'b0; waitCyc(6); extClk = 1'b1; waitCyc(6);
    end
    extInh = 1'b0; waitCyc(6);
    extClk = 1'b0; waitCyc(6);
    chk("R6 qOut held", {7'd0, qOut}, 8'h00);
    readOut(v);
    chk("R6 contents", v, 8'h5A);
  endtask

  task automatic testRelease();
    logic [7:0] v;
    parIn = 8'hB3; extClk = 1'b0; shLdN = 1'b0; waitCyc(4);
    extClk = 1'b1; waitCyc(6);
    shLdN = 1'b1; waitCyc(6);
    chk("R8 qOut after release", {7'd0, qOut}, 8'h01);
    extClk = 1'b0; waitCyc(6);
    readOut(v);
    chk("R8 contents", v, 8'hB3);
  endtask

  initial begin
    repeat (150000) @(posedge sysClk);
    miscompares++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    testReset();
    testLoadShift();
    testParIgnored();
    testInhShift();
    testHold();
    testRelease();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule